// File: doc/BRIEF.md
# Reverse Pointer-Chain Table Initializer

This block fills a region of memory with a backward-linked chain of empty list nodes. It acts as the data source for a write-to-memory transfer that steps its destination address downward. Each generated word points at the entry four bytes below its own address. The entry written last, at the lowest address, holds an end-of-list marker instead of a pointer. Once the table is filled, a consumer can start at the highest entry and follow the pointers down to the marker without knowing the table length.

A one-cycle start pulse loads a base address and a word count. The block then issues one write per clock on a simple write port (strobe, address, data). The first write goes to the base address, rounded down to a word boundary, and each later write goes one word lower. All address arithmetic wraps within 24 bits. Inside the block, a remaining-word counter is decremented before each word is produced, and the word that takes the counter to zero carries the marker. A one-cycle done pulse follows the final write.

Top module: `chain_tbl_filler`

## Requirements
- R1: While reset is asserted and after it is released with no start, `wr_en`, `done` and `busy` are 0.
- R2: A start sampled while idle loads the base address with bits 1:0 cleared. `busy` is 1 after that edge. The first write strobe appears after the next rising edge.
- R3: Each write address after the first in a run is 4 below the previous one, modulo 2^24.
- R4: Every word except the last of a run has bits 23:0 equal to (its write address − 4) mod 2^24, and bits 31:24 equal to 0.
- R5: The last word of a run is 0x00FFFFFF, the end-of-list marker.
- R6: A count N ≥ 1 produces exactly N writes, one per clock cycle and with no gaps.
- R7: A count of 0 produces exactly one write, and that write carries the marker.
- R8: `done` is high for exactly one cycle, on the edge after the final write. At that edge `wr_en` and `busy` are 0.
- R9: A start pulse that arrives while `busy` is 1 has no effect on the addresses, data or length of the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle request to begin a fill |
| base_addr | input | 24 | Highest (first) destination address of the table |
| word_cnt | input | CW (16) | Number of entries; 0 is treated as 1 |
| busy | output | 1 | Run in progress |
| wr_en | output | 1 | Write strobe to memory |
| wr_addr | output | 24 | Write address |
| wr_data | output | 32 | Link word or end-of-list marker |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The in-module assertions check on every cycle that consecutive writes step down by one word, that every non-final word points 4 below its own address, that the marker is always followed by a single done pulse, and that the remaining count falls by one per active cycle. Other properties can only be shown by the bench's sweeps over base addresses and counts. These include the exact run length, zero-count handling, alignment of an odd base, wrap through address zero, and the fact that a start during a run is ignored. The bench also walks the filled memory image from its top entry to confirm the chain is closed.

// File: rtl/ctf_pkg.sv
package ctf_pkg;

  typedef enum logic {
    CTF_IDLE = 1'b0,
    CTF_RUN  = 1'b1
  } ctf_state_e;

  localparam int unsigned CTF_STRIDE = 4;

endpackage

// File: rtl/ctf_ctrl.sv
module ctf_ctrl
  import ctf_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt,
  output logic          busy,
  output logic          load,
  output logic          step,
  output logic          last
);

  ctf_state_e    state_q, state_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          rem_en;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    rem_en  = 1'b0;
    load    = 1'b0;
    case (state_q)
      CTF_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = CTF_RUN;
          rem_en  = 1'b1;
          rem_d   = (cnt == '0) ? CW'(1) : cnt;
        end
      end
      CTF_RUN: begin
        rem_en = 1'b1;
        rem_d  = rem_q - CW'(1);
        if (rem_d == '0) state_d = CTF_IDLE;
      end
      default: state_d = CTF_IDLE;
    endcase
  end

  assign busy = (state_q == CTF_RUN);
  assign step = busy;
  assign last = busy && (rem_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTF_IDLE;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      if (rem_en) rem_q <= rem_d;
    end
  end

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CTF_RUN) |=> (rem_q == $past(rem_q) - CW'(1)));

endmodule

// File: rtl/ctf_addr_step.sv
module ctf_addr_step
  import ctf_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load | step;
    if (load) addr_d = {base[AW-1:2], 2'b00};
    else      addr_d = addr - AW'(CTF_STRIDE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_en) addr <= addr_d;
  end

endmodule

// File: rtl/ctf_link_word.sv
module ctf_link_word
  import ctf_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          last,
  output logic [DW-1:0] word
);

  localparam int unsigned PADW = DW - AW;

  logic [AW-1:0] prev;

  assign prev = addr - AW'(CTF_STRIDE);
  assign word = last ? {{PADW{1'b0}}, {AW{1'b1}}} : {{PADW{1'b0}}, prev};

endmodule

// File: rtl/chain_tbl_filler.sv
module chain_tbl_filler
  import ctf_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] word_cnt,
  output logic          busy,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done
);

  localparam int unsigned PADW = DW - AW;
  localparam logic [DW-1:0] END_MARK = {{PADW{1'b0}}, {AW{1'b1}}};

  logic          load, step, last;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] link;
  logic          wr_last_q;

  ctf_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt(word_cnt),
    .busy(busy), .load(load), .step(step), .last(last)
  );

  ctf_addr_step #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .base(base_addr), .addr(cur_addr)
  );

  ctf_link_word #(.AW(AW), .DW(DW)) u_link (
    .addr(cur_addr), .last(last), .word(link)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      wr_last_q <= 1'b0;
      done      <= 1'b0;
    end else begin
      wr_en     <= step;
      wr_last_q <= last;
      done      <= wr_en & wr_last_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_data <= '0;
    end else if (step) begin
      wr_addr <= cur_addr;
      wr_data <= link;
    end
  end

  // R3
  addr_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) - AW'(CTF_STRIDE)));

  // R4
  link_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != END_MARK) |-> (wr_data == {{PADW{1'b0}}, wr_addr - AW'(CTF_STRIDE)}));

  // R8
  done_after_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == END_MARK) |=> (done && !wr_en && !busy));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/chain_tbl_filler_tb.sv
module chain_tbl_filler_tb;

  localparam int unsigned AW = 24;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 16;
  localparam logic [DW-1:0] MARK = 32'h00FF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] word_cnt = '0;
  logic          busy, wr_en, done;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] mem [int];

  always #2.5 clk = ~clk;

  chain_tbl_filler #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_cnt(word_cnt), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done)
  );

  always @(posedge clk) if (wr_en) mem[int'(wr_addr)] = wr_data;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] base, input int cnt, input bit poke);
    int n;
    logic [AW-1:0] a0, ai;
    logic [31:0] ed;
    int p, hops;
    n  = (cnt == 0) ? 1 : cnt;
    a0 = {base[AW-1:2], 2'b00};
    @(negedge clk);
    base_addr = base; word_cnt = CW'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !wr_en, "R2 busy-before-first-write", {30'd0, busy, wr_en}, 32'h2);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ai = a0 - AW'(4 * i);
      ed = (i == n - 1) ? MARK : {8'h00, ai - AW'(4)};
      if (i == 0) check(wr_addr == a0, "R2 first-address", {8'h0, wr_addr}, {8'h0, a0});
      check(wr_en == 1'b1, "R6 strobe", {31'd0, wr_en}, 32'd1);
      check(wr_addr == ai, "R3 address", {8'h0, wr_addr}, {8'h0, ai});
      if (i == n - 1) check(wr_data == ed, (cnt == 0) ? "R7 zero-count" : "R5 marker", wr_data, ed);
      else            check(wr_data == ed, "R4 link", wr_data, ed);
      if (poke && i == 1) begin
        base_addr = 24'h000800; word_cnt = CW'(2); start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    @(negedge clk);
    check(!wr_en && done && !busy, "R8 done", {29'd0, wr_en, done, busy}, 32'h2);
    @(negedge clk);
    check(!done && !wr_en, poke ? "R9 no-restart" : "R8 pulse", {30'd0, done, wr_en}, 32'h0);
    p = int'(a0); hops = 0;
    while (mem.exists(p) && mem[p] != MARK && hops <= n) begin
      p = int'(mem[p][23:0]); hops++;
    end
    check(hops == n - 1 && mem.exists(p) && mem[p] == MARK, "R6 chain-length", 32'(hops), 32'(n - 1));
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] bases [6];
    bases = '{24'h000100, 24'h000000, 24'h000006, 24'hFFFFFC, 24'h000010, 24'h7FFFF3};
    repeat (3) @(negedge clk);
    check(!wr_en && !done && !busy, "R1 in-reset", {29'd0, wr_en, done, busy}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!wr_en && !done && !busy, "R1 after-reset", {29'd0, wr_en, done, busy}, 32'h0);
    foreach (bases[b]) begin
      for (int c = 0; c <= 5; c++) run(bases[b], c, 1'b0);
    end
    run(24'h000040, 40, 1'b0);
    run(24'h000200, 6, 1'b1);
    check(!mem.exists(32'h000800), "R9 ignored-start-memory", 32'(mem.exists(32'h000800)), 32'h0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule